// File: doc/BRIEF.md
# Processor power-down mode controller

This block sequences the clocks of a processor subsystem through three graded sleep depths. Software writes a 6-bit power-down code through a one-cycle write strobe. Light sleep gates only the CPU core clock. The interrupt logic and the DMA-to-memory path stay clocked, so transfers continue during light sleep. Medium sleep stops the PLL output clock, which halts the whole chip. Deep sleep stops the reference clock into the PLL as well.

Medium and deep sleep raise an I/O hold so that every functional output keeps its last value. Each depth has its own exit:

- One light variant wakes only on an enabled interrupt line.
- The other light variant wakes on any interrupt line.
- Medium and deep sleep leave only on a device reset.

After deep sleep, the clocks stay off until a relock counter has run out and the PLL reports lock.

While a debug probe is attached, sleep requests are held back and the core keeps running. Any wake-up clears the stored code, so software must rewrite it to sleep again.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After `rst_ni` the three clock enables are 1, `io_hold_o` is 0, `mode_o` is 000000, and `relock_busy_o` and `bad_mode_o` are 0.
- R2: Accepted codes are 000000 (none), 001001 (light, enabled irq), 010001 (light, any irq), 011010 (medium) and 011100 (deep). A write in the running state shows on `mode_o` one cycle after the strobe. The gates follow one cycle later.
- R3: Light sleep drives `cpu_clk_en_o`=0 with both PLL enables at 1 and the hold at 0. Code 001001 wakes when some line i has both `irq_i[i]` and `irq_en_i[i]` high. Code 010001 wakes on any high `irq_i` bit. `dbg_resume_i` or `sys_reset_i` also wakes either light variant.
- R4: Medium sleep drives the CPU and PLL-output enables to 0 and `io_hold_o` to 1. Only `sys_reset_i` ends it. Interrupts and `dbg_resume_i` have no effect.
- R5: Deep sleep drives all three enables to 0 and `io_hold_o` to 1. Only `sys_reset_i` ends it, and it starts the relock wait.
- R6: During the relock wait `relock_busy_o`=1, the reference enable is 1, and the CPU and PLL-output enables are 0 with the hold at 1. The wait ends in the first cycle after `RELOCK_CYCLES` counted cycles in which `pll_lock_i` is high.
- R7: While `emu_present_i`=1, a stored sleep code leaves all enables at 1. Dropping `emu_present_i` then enters that sleep.
- R8: Writing any other code stores 000000, leaves the gates running and sets `bad_mode_o`. The flag stays set until `rst_ni`.
- R9: Every wake-up clears `mode_o` to 000000 and restores the running gates.
- R10: Writes made while not running are ignored and `mode_o` keeps its code.
- R11: `sys_reset_i` in the running state clears a pending code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | always-on control clock |
| rst_ni | input | 1 | asynchronous active-low reset of this block |
| wr_en_i | input | 1 | write strobe for the power-down code |
| wr_data_i | input | 6 | power-down code |
| irq_i | input | IRQ_N | interrupt lines |
| irq_en_i | input | IRQ_N | per-line interrupt enable mask |
| emu_present_i | input | 1 | debug probe attached, masks sleep |
| dbg_resume_i | input | 1 | debug run/step command |
| sys_reset_i | input | 1 | device reset request, wakes any sleep |
| pll_lock_i | input | 1 | PLL lock indication |
| cpu_clk_en_o | output | 1 | CPU core clock gate enable |
| pll_out_en_o | output | 1 | PLL output clock enable |
| pll_ref_en_o | output | 1 | PLL reference clock enable |
| io_hold_o | output | 1 | freeze functional I/O |
| mode_o | output | 6 | current power-down code |
| relock_busy_o | output | 1 | relock wait in progress |
| bad_mode_o | output | 1 | sticky reserved-code flag |

## Verification
The hardest state to reach from the ports is a relock wait that outlives its counter because lock is missing. Reaching it takes an entry into deep sleep, then a reset pulse with `pll_lock_i` held low, then an idle stretch well past `RELOCK_CYCLES`. The stimulus does this in a directed sequence. Random trials choose among the codes, random reserved values, interrupt vectors and masks, and each trial is followed by the matching exit path.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  localparam int unsigned MODE_W = 6;

  localparam logic [MODE_W-1:0] PD_NONE      = 6'b000000;
  localparam logic [MODE_W-1:0] PD_LIGHT_EN  = 6'b001001;
  localparam logic [MODE_W-1:0] PD_LIGHT_ANY = 6'b010001;
  localparam logic [MODE_W-1:0] PD_MEDIUM    = 6'b011010;
  localparam logic [MODE_W-1:0] PD_DEEP      = 6'b011100;

  typedef enum logic [2:0] {
    K_NONE, K_LIGHT_EN, K_LIGHT_ANY, K_MEDIUM, K_DEEP, K_BAD
  } pd_kind_e;

  typedef enum logic [2:0] {
    S_RUN, S_LIGHT_EN, S_LIGHT_ANY, S_MEDIUM, S_DEEP, S_RELOCK
  } pd_state_e;

  typedef struct packed {
    logic cpu;
    logic pll_out;
    logic pll_ref;
    logic hold;
  } gate_t;
endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_sleep_pkg::*;
(
  input  logic [MODE_W-1:0] code_i,
  output pd_kind_e          kind_o
);
  always_comb begin
    case (code_i)
      PD_NONE:      kind_o = K_NONE;
      PD_LIGHT_EN:  kind_o = K_LIGHT_EN;
      PD_LIGHT_ANY: kind_o = K_LIGHT_ANY;
      PD_MEDIUM:    kind_o = K_MEDIUM;
      PD_DEEP:      kind_o = K_DEEP;
      default:      kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/pwr_relock_timer.sv
module pwr_relock_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= CW'(CYCLES);
    else if (run_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R6: a fresh load never reports expiry on the next cycle
  a_r6_load_not_expired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !expired_o);
  // R6: an expired counter stays expired until reloaded
  a_r6_expired_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !load_i |=> expired_o);
endmodule

// File: rtl/pwr_wake_fsm.sv
module pwr_wake_fsm
  import pwr_sleep_pkg::*;
#(
  parameter int unsigned IRQ_N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_data_i,
  input  pd_kind_e          wr_kind_i,
  input  pd_kind_e          field_kind_i,
  input  logic [IRQ_N-1:0]  irq_i,
  input  logic [IRQ_N-1:0]  irq_en_i,
  input  logic              emu_i,
  input  logic              dbg_resume_i,
  input  logic              sys_reset_i,
  input  logic              lock_i,
  input  logic              relock_expired_i,
  output logic [MODE_W-1:0] field_o,
  output logic              bad_o,
  output logic              relock_load_o,
  output logic              relock_run_o,
  output gate_t             gate_o
);
  pd_state_e         state_q, state_d;
  logic [MODE_W-1:0] field_q, field_d;
  logic              bad_q, bad_d;
  logic [IRQ_N-1:0]  en_hit;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_line
    assign en_hit[g] = irq_i[g] & irq_en_i[g];
  end

  always_comb begin
    state_d       = state_q;
    field_d       = field_q;
    bad_d         = bad_q;
    relock_load_o = 1'b0;
    case (state_q)
      S_RUN: begin
        if (sys_reset_i) begin
          field_d = PD_NONE;
        end else if (wr_en_i) begin
          if (wr_kind_i == K_BAD) begin
            field_d = PD_NONE;
            bad_d   = 1'b1;
          end else begin
            field_d = wr_data_i;
          end
        end else if (!emu_i) begin
          case (field_kind_i)
            K_LIGHT_EN:  state_d = S_LIGHT_EN;
            K_LIGHT_ANY: state_d = S_LIGHT_ANY;
            K_MEDIUM:    state_d = S_MEDIUM;
            K_DEEP:      state_d = S_DEEP;
            default:     state_d = S_RUN;
          endcase
        end
      end
      S_LIGHT_EN: if ((|en_hit) || dbg_resume_i || sys_reset_i) begin
        state_d = S_RUN;
        field_d = PD_NONE;
      end
      S_LIGHT_ANY: if ((|irq_i) || dbg_resume_i || sys_reset_i) begin
        state_d = S_RUN;
        field_d = PD_NONE;
      end
      S_MEDIUM: if (sys_reset_i) begin
        state_d = S_RUN;
        field_d = PD_NONE;
      end
      S_DEEP: if (sys_reset_i) begin
        state_d       = S_RELOCK;
        relock_load_o = 1'b1;
      end
      S_RELOCK: if (relock_expired_i && lock_i) begin
        state_d = S_RUN;
        field_d = PD_NONE;
      end
      default: begin
        state_d = S_RUN;
        field_d = PD_NONE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RUN;
      field_q <= PD_NONE;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      field_q <= field_d;
      bad_q   <= bad_d;
    end
  end

  always_comb begin
    case (state_q)
      S_LIGHT_EN, S_LIGHT_ANY: gate_o = '{cpu: 1'b0, pll_out: 1'b1, pll_ref: 1'b1, hold: 1'b0};
      S_MEDIUM, S_RELOCK:      gate_o = '{cpu: 1'b0, pll_out: 1'b0, pll_ref: 1'b1, hold: 1'b1};
      S_DEEP:                  gate_o = '{cpu: 1'b0, pll_out: 1'b0, pll_ref: 1'b0, hold: 1'b1};
      default:                 gate_o = '{cpu: 1'b1, pll_out: 1'b1, pll_ref: 1'b1, hold: 1'b0};
    endcase
  end

  assign relock_run_o = (state_q == S_RELOCK);
  assign field_o      = field_q;
  assign bad_o        = bad_q;

  a_r2_field_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_kind_i != K_BAD);
  a_r4_medium_reset_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_MEDIUM && !sys_reset_i |=> state_q == S_MEDIUM);
  a_r5_deep_reset_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_DEEP && !sys_reset_i |=> state_q == S_DEEP);
  a_r6_wait_for_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_RELOCK && !lock_i |=> state_q == S_RELOCK);
  a_r7_emu_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_RUN && emu_i |=> state_q == S_RUN);
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_q |=> bad_q);
  a_r9_wake_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_RUN && $past(state_q) != S_RUN |-> field_q == PD_NONE);
  a_r10_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != S_RUN && state_q != S_RELOCK && !$past(wr_en_i && state_q == S_RUN) && wr_en_i
    |=> field_q == PD_NONE || $stable(field_q));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int unsigned IRQ_N         = 8,
  parameter int unsigned RELOCK_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_data_i,
  input  logic [IRQ_N-1:0]  irq_i,
  input  logic [IRQ_N-1:0]  irq_en_i,
  input  logic              emu_present_i,
  input  logic              dbg_resume_i,
  input  logic              sys_reset_i,
  input  logic              pll_lock_i,
  output logic              cpu_clk_en_o,
  output logic              pll_out_en_o,
  output logic              pll_ref_en_o,
  output logic              io_hold_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              relock_busy_o,
  output logic              bad_mode_o
);
  pd_kind_e wr_kind, field_kind;
  logic     relock_load, relock_run, relock_expired;
  gate_t    gate;

  pwr_mode_decode u_wr_dec (.code_i(wr_data_i), .kind_o(wr_kind));
  pwr_mode_decode u_fd_dec (.code_i(mode_o),    .kind_o(field_kind));

  pwr_relock_timer #(.CYCLES(RELOCK_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .load_i(relock_load), .run_i(relock_run), .expired_o(relock_expired)
  );

  pwr_wake_fsm #(.IRQ_N(IRQ_N)) u_fsm (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_data_i,
    .wr_kind_i(wr_kind), .field_kind_i(field_kind),
    .irq_i, .irq_en_i,
    .emu_i(emu_present_i), .dbg_resume_i, .sys_reset_i,
    .lock_i(pll_lock_i), .relock_expired_i(relock_expired),
    .field_o(mode_o), .bad_o(bad_mode_o),
    .relock_load_o(relock_load), .relock_run_o(relock_run),
    .gate_o(gate)
  );

  assign cpu_clk_en_o  = gate.cpu;
  assign pll_out_en_o  = gate.pll_out;
  assign pll_ref_en_o  = gate.pll_ref;
  assign io_hold_o     = gate.hold;
  assign relock_busy_o = relock_run;

  a_r5_hold_when_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hold_o |-> !pll_out_en_o && !cpu_clk_en_o);
  a_r5_ref_off_deepest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_ref_en_o |-> !pll_out_en_o && io_hold_o);
  a_r6_busy_clocks_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_busy_o |-> !cpu_clk_en_o && pll_ref_en_o);
endmodule

// File: tb/sim_pwr_sleep_ctrl.sv
module sim_pwr_sleep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IRQ_N      = 4;
  localparam int RELOCK     = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic [IRQ_N-1:0] irq = '0, irq_en = '0;
  logic emu = 1'b0, dbg = 1'b0, sys_rst = 1'b0, lock = 1'b1;
  logic cpu_en, out_en, ref_en, hold, busy, bad;
  logic [5:0] mode;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_sleep_ctrl #(.IRQ_N(IRQ_N), .RELOCK_CYCLES(RELOCK)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .irq_i(irq), .irq_en_i(irq_en), .emu_present_i(emu), .dbg_resume_i(dbg),
    .sys_reset_i(sys_rst), .pll_lock_i(lock),
    .cpu_clk_en_o(cpu_en), .pll_out_en_o(out_en), .pll_ref_en_o(ref_en),
    .io_hold_o(hold), .mode_o(mode), .relock_busy_o(busy), .bad_mode_o(bad)
  );

  // kinds: 0 none, 1 light-en, 2 light-any, 3 medium, 4 deep, 5 reserved
  function automatic int kind_of(logic [5:0] c);
    case (c)
      6'b000000: return 0;
      6'b001001: return 1;
      6'b010001: return 2;
      6'b011010: return 3;
      6'b011100: return 4;
      default:   return 5;
    endcase
  endfunction

  // {cpu, pll_out, pll_ref, hold}
  function automatic logic [3:0] gates_of(int k);
    case (k)
      1, 2:    return 4'b0110;
      3:       return 4'b0011;
      4:       return 4'b0001;
      default: return 4'b1110;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] c);
    wr_en = 1'b1; wr_data = c; tick(1); wr_en = 1'b0;
  endtask

  task automatic pulse_rst;
    sys_rst = 1'b1; tick(1); sys_rst = 1'b0;
  endtask

  function automatic logic [3:0] g();
    return {cpu_en, out_en, ref_en, hold};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit err_model = 0;
    void'($urandom(32'h5eed_1234));
    tick(2);
    // R1 reset state
    chk("R1 gates", g(), 4'b1110);
    chk("R1 mode", mode, 0);
    chk("R1 busy", busy, 0);
    chk("R1 bad", bad, 0);
    rst_ni = 1'b1;
    tick(1);

    // R7 emulator masks medium sleep
    emu = 1'b1;
    wr(6'b011010);
    chk("R2 mode shown", mode, 6'b011010);
    tick(3);
    chk("R7 masked gates", g(), 4'b1110);
    emu = 1'b0;
    tick(1);
    chk("R7 enter after unmask", g(), 4'b0011);
    // R4 medium ignores irq and debug resume
    irq = '1; irq_en = '1; dbg = 1'b1;
    tick(2);
    irq = '0; dbg = 1'b0;
    chk("R4 no wake", g(), 4'b0011);
    chk("R4 mode kept", mode, 6'b011010);
    pulse_rst;
    chk("R9 medium wake", g(), 4'b1110);
    chk("R9 mode cleared", mode, 0);

    // R3 light wakes on debug resume
    wr(6'b001001); tick(1);
    chk("R3 light gates", g(), 4'b0110);
    irq = 4'b0101; irq_en = 4'b1010;
    tick(1); irq = '0;
    chk("R3 masked irq no wake", g(), 4'b0110);
    // R10 write while asleep ignored
    wr(6'b011100);
    tick(1);
    chk("R10 mode kept", mode, 6'b001001);
    chk("R10 gates kept", g(), 4'b0110);
    dbg = 1'b1; tick(1); dbg = 1'b0;
    chk("R3 resume wake", g(), 4'b1110);

    // R5/R6 deep with late lock
    wr(6'b011100); tick(1);
    chk("R5 deep gates", g(), 4'b0001);
    irq = '1; irq_en = '1; tick(2); irq = '0;
    chk("R5 irq ignored", g(), 4'b0001);
    lock = 1'b0;
    pulse_rst;
    chk("R6 busy", busy, 1);
    chk("R6 relock gates", g(), 4'b0011);
    tick(RELOCK + 4);
    chk("R6 waits for lock", busy, 1);
    chk("R6 cpu still off", cpu_en, 0);
    lock = 1'b1;
    tick(1);
    chk("R6 released", g(), 4'b1110);
    chk("R6 busy clear", busy, 0);
    chk("R9 deep mode cleared", mode, 0);

    // R6 exact count with lock held high
    wr(6'b011100); tick(1);
    pulse_rst;
    tick(RELOCK);
    chk("R6 last wait cycle", busy, 1);
    tick(1);
    chk("R6 on time", g(), 4'b1110);

    // R11 device reset clears pending code
    emu = 1'b1;
    wr(6'b010001);
    pulse_rst;
    chk("R11 cleared", mode, 0);
    emu = 1'b0;
    tick(2);
    chk("R11 stays running", g(), 4'b1110);

    // R8 reserved code
    wr(6'b111111);
    chk("R8 mode none", mode, 0);
    chk("R8 flag", bad, 1);
    tick(1);
    chk("R8 gates", g(), 4'b1110);
    err_model = 1;

    // random trials
    for (int it = 0; it < 60; it++) begin
      logic [5:0] code;
      logic [IRQ_N-1:0] ri, rm;
      int k;
      bit woke;
      case ($urandom % 6)
        0: code = 6'b000000;
        1: code = 6'b001001;
        2: code = 6'b010001;
        3: code = 6'b011010;
        4: code = 6'b011100;
        default: code = 6'($urandom);
      endcase
      k = kind_of(code);
      wr(code);
      if (k == 5) err_model = 1;
      chk("R2 random mode", mode, (k == 5) ? 0 : code);
      chk("R8 random flag", bad, err_model);
      tick(1);
      chk("R2 random gates", g(), gates_of(k));
      ri = IRQ_N'($urandom); rm = IRQ_N'($urandom);
      irq = ri; irq_en = rm;
      tick(1); irq = '0;
      woke = (k == 1 && (ri & rm) != 0) || (k == 2 && ri != 0);
      chk("R3 random wake", g(), woke ? 4'b1110 : gates_of(k));
      if (woke) chk("R9 random clear", mode, 0);
      if (!woke && k >= 1 && k <= 4) begin
        pulse_rst;
        if (k == 4) tick(RELOCK + 1);
        chk("R9 random restore", g(), 4'b1110);
        chk("R9 random mode", mode, 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule